// File: doc/BRIEF.md
# Accumulator Register-Reference Execution Unit

This block carries out the register-only operations of a small accumulator machine. It holds a 16-bit accumulator and a one-bit extension flag that sits beside it. Each operation is picked by its own bit in a 12-bit operation field, and acts only when the execute strobe for the register-reference step is high. The field is one-hot in normal use. When several bits are set together, every selected operation applies, in a fixed order.

The results are registered. One clock edge after a strobe, the block shows the new accumulator and extension values. In that same cycle it raises three one-cycle pulses: a request to step the program counter past the next instruction (a skip), a halt pulse that stops the machine, and a request to clear the step counter. Outside register-reference steps, other parts of the machine can load the accumulator and extension flag through a parallel load port.

Top module: `rref_exec_unit`

## Requirements
- R1: After reset the accumulator and extension flag are 0, and the skip, halt and step-clear outputs are low.
- R2: With the strobe high, op bit 11 clears the accumulator and op bit 10 clears the extension flag.
- R3: With the strobe high, op bit 9 inverts every accumulator bit and op bit 8 inverts the extension flag.
- R4: With the strobe high, op bit 7 rotates the 17-bit ring {accumulator, extension} right by one place: the extension flag moves into accumulator bit 15, and accumulator bit 0 moves into the extension flag.
- R5: With the strobe high, op bit 6 rotates the ring left by one place: the extension flag moves into accumulator bit 0, and accumulator bit 15 moves into the extension flag.
- R6: With the strobe high, op bit 5 adds one to the accumulator modulo 2^16. The extension flag does not change.
- R7: With the strobe high, a skip pulse appears one cycle later if any selected test holds: bit 4 when accumulator bit 15 is 0, bit 3 when it is 1, bit 2 when the accumulator is all zeros, bit 1 when the extension flag is 0. The tests use the values from before that strobe's update.
- R8: With the strobe high, op bit 0 gives a halt pulse of one cycle, in the cycle after the strobe.
- R9: Every strobe gives a step-clear pulse of one cycle, in the cycle after the strobe, whatever the op bits are.
- R10: Without the strobe, the op bits have no effect. The skip, halt and step-clear outputs stay low, and the accumulator and extension flag hold their values unless a load is requested.
- R11: With the load enable high and no strobe, the accumulator and extension flag take the load values at the next edge. If the strobe is high in the same cycle, the load is ignored.
- R12: When several op bits are set, the operations apply in this order: accumulator clear, extension clear, accumulator invert, extension invert, right rotate, left rotate, increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_stb | input | 1 | Register-reference execute strobe |
| op_bits | input | 12 | Operation select field (instruction bits 11..0) |
| ld_en | input | 1 | Parallel load enable |
| ld_val | input | 16 | Accumulator load value |
| ld_ext | input | 1 | Extension flag load value |
| acc_o | output | 16 | Accumulator |
| ext_o | output | 1 | Extension flag |
| skip_o | output | 1 | Skip request pulse |
| halt_o | output | 1 | Halt pulse |
| sc_clr_o | output | 1 | Step-counter clear request pulse |

## Verification
Some properties are checked on every cycle by assertions:
- the three pulses follow a strobe by one cycle and never appear without one;
- the state holds when the cycle is idle;
- a lone increment and the two lone rotates match their one-step definitions;
- a load takes its value on the next edge.

Other behaviour only the bench's scenarios can show:
- the composed results when several op bits are set together;
- the fact that a skip test reads the accumulator from before the update, for example a clear combined with the zero test;
- the increment wrapping at all ones;
- a load losing to a strobe in the same cycle.

// File: rtl/rref_pkg.sv
package rref_pkg;
    localparam int OP_W      = 12;
    // positions inside the operation field
    localparam int B_CLR_AC  = 11;
    localparam int B_CLR_E   = 10;
    localparam int B_INV_AC  = 9;
    localparam int B_INV_E   = 8;
    localparam int B_ROT_R   = 7;
    localparam int B_ROT_L   = 6;
    localparam int B_INC     = 5;
    localparam int B_TST_HI  = 4;
    localparam int B_TST_LO  = 1;
    localparam int B_HALT    = 0;
    // widths of the slices handed to the sub-blocks
    localparam int XFORM_W   = B_CLR_AC - B_INC + 1;
    localparam int TEST_W    = B_TST_HI - B_TST_LO + 1;
    // indices inside the test slice
    localparam int T_SZE     = 0;
    localparam int T_SZA     = 1;
    localparam int T_NEG     = 2;
    localparam int T_POS     = 3;
endpackage

// File: rtl/rref_acc_path.sv
module rref_acc_path
    import rref_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0]   acc_i,
    input  logic               ext_i,
    input  logic [XFORM_W-1:0] xf_i,
    output logic [ACC_W-1:0]   acc_o,
    output logic               ext_o
);
    localparam int K_CLR_AC = B_CLR_AC - B_INC;
    localparam int K_CLR_E  = B_CLR_E  - B_INC;
    localparam int K_INV_AC = B_INV_AC - B_INC;
    localparam int K_INV_E  = B_INV_E  - B_INC;
    localparam int K_ROT_R  = B_ROT_R  - B_INC;
    localparam int K_ROT_L  = B_ROT_L  - B_INC;
    localparam int K_INC    = 0;

    logic [ACC_W-1:0] a;
    logic             e;

    always_comb begin
        a = acc_i;
        e = ext_i;
        if (xf_i[K_CLR_AC]) a = '0;
        if (xf_i[K_CLR_E])  e = 1'b0;
        if (xf_i[K_INV_AC]) a = ~a;
        if (xf_i[K_INV_E])  e = ~e;
        if (xf_i[K_ROT_R])  {a, e} = {e, a};
        if (xf_i[K_ROT_L])  {e, a} = {a, e};
        if (xf_i[K_INC])    a = a + {{(ACC_W-1){1'b0}}, 1'b1};
        acc_o = a;
        ext_o = e;
    end
endmodule

// File: rtl/rref_skip_eval.sv
module rref_skip_eval
    import rref_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic              ext_i,
    input  logic [TEST_W-1:0] tst_i,
    output logic              skip_o
);
    logic [TEST_W-1:0] hit;

    for (genvar k = 0; k < TEST_W; k++) begin : g_test
        if (k == T_POS) begin : g_pos
            assign hit[k] = tst_i[k] & ~acc_i[ACC_W-1];
        end else if (k == T_NEG) begin : g_neg
            assign hit[k] = tst_i[k] & acc_i[ACC_W-1];
        end else if (k == T_SZA) begin : g_zero
            assign hit[k] = tst_i[k] & ~(|acc_i);
        end else begin : g_ext
            assign hit[k] = tst_i[k] & ~ext_i;
        end
    end

    assign skip_o = |hit;
endmodule

// File: rtl/rref_exec_unit.sv
module rref_exec_unit
    import rref_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_stb,
    input  logic [OP_W-1:0]  op_bits,
    input  logic             ld_en,
    input  logic [ACC_W-1:0] ld_val,
    input  logic             ld_ext,
    output logic [ACC_W-1:0] acc_o,
    output logic             ext_o,
    output logic             skip_o,
    output logic             halt_o,
    output logic             sc_clr_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ext;
        logic             skip;
        logic             halt;
        logic             sc_clr;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [ACC_W-1:0] xf_acc;
    logic             xf_ext;
    logic             test_hit;

    rref_acc_path #(.ACC_W(ACC_W)) u_path (
        .acc_i (st_q.acc),
        .ext_i (st_q.ext),
        .xf_i  (op_bits[B_CLR_AC:B_INC]),
        .acc_o (xf_acc),
        .ext_o (xf_ext)
    );

    rref_skip_eval #(.ACC_W(ACC_W)) u_skip (
        .acc_i  (st_q.acc),
        .ext_i  (st_q.ext),
        .tst_i  (op_bits[B_TST_HI:B_TST_LO]),
        .skip_o (test_hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.skip   = 1'b0;
        st_d.halt   = 1'b0;
        st_d.sc_clr = 1'b0;
        if (exec_stb) begin
            st_d.acc    = xf_acc;
            st_d.ext    = xf_ext;
            st_d.skip   = test_hit;
            st_d.halt   = op_bits[B_HALT];
            st_d.sc_clr = 1'b1;
        end else if (ld_en) begin
            st_d.acc = ld_val;
            st_d.ext = ld_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o    = st_q.acc;
    assign ext_o    = st_q.ext;
    assign skip_o   = st_q.skip;
    assign halt_o   = st_q.halt;
    assign sc_clr_o = st_q.sc_clr;
endmodule

// File: rtl/rref_exec_unit_chk.sv
module rref_exec_unit_chk #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_stb,
    input logic [11:0]      op_bits,
    input logic             ld_en,
    input logic [ACC_W-1:0] ld_val,
    input logic             ld_ext,
    input logic [ACC_W-1:0] acc_o,
    input logic             ext_o,
    input logic             skip_o,
    input logic             halt_o,
    input logic             sc_clr_o
);
    p_stepclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> sc_clr_o);

    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_bits[0]) |=> halt_o);

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_stb |=> (!skip_o && !halt_o && !sc_clr_o));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_stb && !ld_en) |=> ($stable(acc_o) && $stable(ext_o)));

    p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_bits == 12'h020) |=>
            (acc_o == $past(acc_o) + 1'b1 && $stable(ext_o)));

    p_rotr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_bits == 12'h080) |=>
            ({acc_o, ext_o} == {$past(ext_o), $past(acc_o)}));

    p_rotl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_bits == 12'h040) |=>
            ({ext_o, acc_o} == {$past(acc_o), $past(ext_o)}));

    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_stb && ld_en) |=> (acc_o == $past(ld_val) && ext_o == $past(ld_ext)));

    p_skipneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_bits[3] && acc_o[ACC_W-1]) |=> skip_o);
endmodule

bind rref_exec_unit rref_exec_unit_chk #(.ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_stb (exec_stb),
    .op_bits  (op_bits),
    .ld_en    (ld_en),
    .ld_val   (ld_val),
    .ld_ext   (ld_ext),
    .acc_o    (acc_o),
    .ext_o    (ext_o),
    .skip_o   (skip_o),
    .halt_o   (halt_o),
    .sc_clr_o (sc_clr_o)
);

// File: tb/rref_exec_unit_tb.sv
module rref_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_stb = 1'b0;
    logic [11:0] op_bits = '0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_val = '0;
    logic        ld_ext = 1'b0;
    logic [15:0] acc_o;
    logic        ext_o, skip_o, halt_o, sc_clr_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rref_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .op_bits(op_bits),
        .ld_en(ld_en), .ld_val(ld_val), .ld_ext(ld_ext),
        .acc_o(acc_o), .ext_o(ext_o), .skip_o(skip_o),
        .halt_o(halt_o), .sc_clr_o(sc_clr_o)
    );

    typedef struct {
        logic [15:0] acc;
        logic        ext;
        logic        skip;
        logic        halt;
        logic        sc;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [15:0] sh_acc = '0;
    logic        sh_ext = 1'b0;

    // expected behaviour, written from the requirement list
    task automatic drive(input logic stb, input logic [11:0] op,
                         input logic ld, input logic [15:0] lv, input logic le,
                         input string tag);
        exp_t x;
        logic [15:0] a;
        logic        e, t;
        @(negedge clk);
        exec_stb = stb; op_bits = op; ld_en = ld; ld_val = lv; ld_ext = le;
        a = sh_acc; e = sh_ext;
        x.skip = 1'b0; x.halt = 1'b0; x.sc = 1'b0;
        if (stb) begin
            x.skip = (op[4] && a[15] == 1'b0) || (op[3] && a[15] == 1'b1) ||
                     (op[2] && a == 16'h0000) || (op[1] && e == 1'b0);
            x.halt = op[0];
            x.sc   = 1'b1;
            if (op[11]) a = 16'h0000;
            if (op[10]) e = 1'b0;
            if (op[9])  a = a ^ 16'hFFFF;
            if (op[8])  e = !e;
            if (op[7]) begin t = a[0]; a = {e, a[15:1]}; e = t; end
            if (op[6]) begin t = a[15]; a = {a[14:0], e}; e = t; end
            if (op[5])  a = a + 16'd1;
        end else if (ld) begin
            a = lv; e = le;
        end
        sh_acc = a; sh_ext = e;
        x.acc = a; x.ext = e; x.tag = tag;
        sb.push_back(x);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            n_vec++;
            if (acc_o !== x.acc || ext_o !== x.ext || skip_o !== x.skip ||
                halt_o !== x.halt || sc_clr_o !== x.sc) begin
                n_bad++;
                $display("FAIL %s: got acc=%h e=%b skip=%b halt=%b sc=%b, want acc=%h e=%b skip=%b halt=%b sc=%b",
                         x.tag, acc_o, ext_o, skip_o, halt_o, sc_clr_o,
                         x.acc, x.ext, x.skip, x.halt, x.sc);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        n_vec++;
        if (acc_o !== 16'h0 || ext_o !== 1'b0 || skip_o || halt_o || sc_clr_o) begin
            n_bad++;
            $display("FAIL R1 reset: got acc=%h e=%b pulses=%b%b%b, want 0000 0 000",
                     acc_o, ext_o, skip_o, halt_o, sc_clr_o);
        end
        @(negedge clk); rst_n = 1'b1;

        drive(0, 12'h000, 1, 16'hA5F0, 1'b1, "R11 load");
        drive(1, 12'h800, 0, 16'h0,    1'b0, "R2 clear acc");
        drive(1, 12'h400, 0, 16'h0,    1'b0, "R2 clear ext");
        drive(1, 12'h200, 0, 16'h0,    1'b0, "R3 invert acc");
        drive(1, 12'h100, 0, 16'h0,    1'b0, "R3 invert ext");
        drive(0, 12'h000, 1, 16'h8001, 1'b0, "R11 load");
        drive(1, 12'h080, 0, 16'h0,    1'b0, "R4 rotate right");
        drive(1, 12'h080, 0, 16'h0,    1'b0, "R4 rotate right again");
        drive(1, 12'h040, 0, 16'h0,    1'b0, "R5 rotate left");
        drive(0, 12'h000, 1, 16'h8000, 1'b1, "R11 load");
        drive(1, 12'h040, 0, 16'h0,    1'b0, "R5 rotate left msb to ext");
        drive(0, 12'h000, 1, 16'hFFFF, 1'b1, "R11 load");
        drive(1, 12'h020, 0, 16'h0,    1'b0, "R6 increment wraps");
        drive(1, 12'h020, 0, 16'h0,    1'b0, "R6 increment");
        drive(1, 12'h010, 0, 16'h0,    1'b0, "R7 skip if positive");
        drive(0, 12'h000, 1, 16'h9000, 1'b0, "R11 load");
        drive(1, 12'h010, 0, 16'h0,    1'b0, "R7 positive test fails");
        drive(1, 12'h008, 0, 16'h0,    1'b0, "R7 skip if negative");
        drive(1, 12'h004, 0, 16'h0,    1'b0, "R7 zero test fails");
        drive(1, 12'h002, 0, 16'h0,    1'b0, "R7 skip if ext zero");
        drive(1, 12'h804, 0, 16'h0,    1'b0, "R7 zero test uses old acc");
        drive(1, 12'h004, 0, 16'h0,    1'b0, "R7 skip if zero");
        drive(1, 12'h001, 0, 16'h0,    1'b0, "R8 halt");
        drive(1, 12'h000, 0, 16'h0,    1'b0, "R9 empty op clears step");
        drive(0, 12'hFFF, 0, 16'h0,    1'b0, "R10 ops ignored without strobe");
        drive(1, 12'h200, 1, 16'h1234, 1'b1, "R11 strobe beats load");
        drive(1, 12'h820, 0, 16'h0,    1'b0, "R12 clear then increment");
        drive(1, 12'h0C0, 0, 16'h0,    1'b0, "R12 right then left");
        drive(1, 12'hFFF, 0, 16'h0,    1'b0, "R12 every bit");
        drive(1, 12'h300, 0, 16'h0,    1'b0, "R12 both inverts");
        drive(0, 12'h000, 0, 16'h0,    1'b0, "R10 idle hold");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule